// File: doc/BRIEF.md
# Bus-Master DMA Status Engine

This block is the bus-master DMA front end that sits between a SCSI protocol core and system memory. Software programs a start byte count, a start physical address and a descriptor pointer, then writes a command. While a transfer is active the protocol core asks for data chunks. The engine trims each chunk to the bytes still owed. It issues one request on a simple request/acknowledge memory port, then moves the working count and working address forward once the request is acknowledged.

In descriptor mode, each chunk begins with a 4-byte pointer fetch from the descriptor pointer. The data address is that pointer ORed with the start physical address. Completion is flagged when the working count reaches zero. It is also flagged when the core raises its interrupt while a start command is in place and nothing remains. A level interrupt output is the OR of the core interrupt and any pending DMA status. Reading the status register clears the completion, error and abort flags, unless a hold bit in the bus-control register keeps them.

Top module: `bmdma_engine`

## Requirements
- R1: After reset, the status register (offset 6) reads 0 and the bus-control register (offset 7) reads 0x00080000. The inta, mem_req and chunk_ready outputs are low.
- R2: A command write (offset 0, bits [1:0]) of 0 (idle) ends any transfer. After it, chunk_ready is low and chunk requests produce no memory request and leave the working count (offset 4) unchanged.
- R3: A command value of 1 (blast) sets status bit 0. Status reads never clear that bit.
- R4: A command value of 3 (start) loads the working count from the start count (offset 1) and the working address (offset 5) from the start address (offset 2). It then makes the engine active. A start written while a transfer is already active is ignored.
- R5: Each chunk length is the smaller of the requested length and the working count. A chunk whose trimmed length is zero issues no memory request.
- R6: In plain mode (command bit 7 = 0), one data request is made at the working address, with mem_is_ptr low. After it is acknowledged, the working count drops by the chunk length and the working address rises by the same amount.
- R7: In descriptor mode (command bit 7 = 1), each chunk first issues a 4-byte request with mem_is_ptr high at the descriptor pointer (offset 3). The working address becomes the returned word ORed with the start address, and the data request uses that address.
- R8: When a chunk brings the working count to zero, or a chunk trims to zero, status bit 3 (DONE) is set and the transfer ends. This holds in both modes.
- R9: A rising core_irq while the command field is 3 and the working count is zero sets DONE. A rising core_irq while the count is nonzero does not.
- R10: A status read clears bits 3 (DONE), 2 (ERROR) and 1 (ABORT), unless bus-control bit 0 (hold) is set. In that case the bits stay set.
- R11: inta follows, one clock later, the OR of core_irq and status bits 3, 2 and 1.
- R12: An acknowledge with mem_err high sets status bit 2 (ERROR) and ends the transfer without changing the working count.
- R13: A command value of 2 (abort) while a transfer is active sets status bit 1 (ABORT) and ends the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data valid the next cycle |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| core_irq | input | 1 | Interrupt level from the SCSI protocol core |
| chunk_req | input | 1 | Core requests one transfer chunk |
| chunk_len | input | CNT_W | Requested chunk length in bytes |
| chunk_ready | output | 1 | Active transfer, sequencer free to take a chunk |
| chunk_done | output | 1 | One-cycle pulse after a data chunk completes |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_addr | output | ADDR_W | Memory request address |
| mem_len | output | CNT_W | Memory request length in bytes |
| mem_is_ptr | output | 1 | Request is a descriptor pointer fetch |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Error flag qualifying mem_ack |
| mem_rdata | input | ADDR_W | Pointer returned on a pointer-fetch acknowledge |
| inta | output | 1 | Level interrupt to the host |

## Verification
The bench builds the engine with CNT_W = 12 and ADDR_W = 32. The narrow count keeps start counts of a few hundred bytes within a handful of chunks, so the trim-to-remaining path and the final chunk are hit on nearly every transfer. The full-width address lets random start addresses and descriptor words carry high bits through the OR and the additions. Random transfers mix both modes with random acknowledge delays. Directed cases cover zero-length starts, a start arriving while a transfer is active, the hold bit, memory errors and abort.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_BLAST = 2'd1,
    CMD_ABORT = 2'd2,
    CMD_START = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_FETCH = 2'd1,
    XS_DATA  = 2'd2
  } xstate_e;

  localparam logic [2:0] A_CMD    = 3'd0;
  localparam logic [2:0] A_SCNT   = 3'd1;
  localparam logic [2:0] A_SADDR  = 3'd2;
  localparam logic [2:0] A_DPTR   = 3'd3;
  localparam logic [2:0] A_WCNT   = 3'd4;
  localparam logic [2:0] A_WADDR  = 3'd5;
  localparam logic [2:0] A_STATUS = 3'd6;
  localparam logic [2:0] A_BUSCTL = 3'd7;

  localparam int ST_BLAST = 0;
  localparam int ST_ABORT = 1;
  localparam int ST_ERROR = 2;
  localparam int ST_DONE  = 3;
  localparam int ST_W     = 4;

  localparam int CMD_DESC_BIT = 7;
  localparam int BC_HOLD_BIT  = 0;
  localparam logic [31:0] BC_RESET = 32'h0008_0000;
endpackage

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              core_irq,
  input  logic              xfer_idle,
  input  logic              ev_zero,
  input  logic              ev_ptr,
  input  logic [ADDR_W-1:0] ev_ptr_addr,
  input  logic              ev_data,
  input  logic [CNT_W-1:0]  ev_len,
  input  logic              ev_err,
  output logic              active,
  output logic              desc_mode,
  output logic [CNT_W-1:0]  wcount,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W-1:0] desc_ptr,
  output logic [ADDR_W-1:0] spa,
  output logic [ST_W-1:0]   status
);
  logic [7:0]        cmd_q;
  logic [CNT_W-1:0]  start_cnt;
  logic [31:0]       busctl;
  logic              core_q;
  logic              core_rise;
  logic              cmd_wr, st_rd;

  logic [ST_W-1:0]   st_n;
  logic              act_n;
  logic [CNT_W-1:0]  wc_n;
  logic [ADDR_W-1:0] wa_n;
  logic [31:0]       rd_mux;

  assign desc_mode = cmd_q[CMD_DESC_BIT];
  assign core_rise = core_irq & ~core_q;
  assign cmd_wr    = reg_wr && (reg_addr == A_CMD);
  assign st_rd     = reg_rd && (reg_addr == A_STATUS);

  always_comb begin
    st_n  = status;
    act_n = active;
    wc_n  = wcount;
    wa_n  = waddr;
    if (st_rd && !busctl[BC_HOLD_BIT]) begin
      st_n[ST_DONE]  = 1'b0;
      st_n[ST_ERROR] = 1'b0;
      st_n[ST_ABORT] = 1'b0;
    end
    if (ev_ptr) wa_n = ev_ptr_addr;
    if (ev_data && !ev_err) begin
      wc_n = wcount - ev_len;
      if (!desc_mode) wa_n = waddr + ADDR_W'(ev_len);
      if (wc_n == '0) begin
        st_n[ST_DONE] = 1'b1;
        act_n = 1'b0;
      end
    end
    if (ev_err) begin
      st_n[ST_ERROR] = 1'b1;
      act_n = 1'b0;
    end
    if (ev_zero) begin
      st_n[ST_DONE] = 1'b1;
      act_n = 1'b0;
    end
    if (core_rise && (cmd_e'(cmd_q[1:0]) == CMD_START) && (wcount == '0)) begin
      st_n[ST_DONE] = 1'b1;
      act_n = 1'b0;
    end
    if (cmd_wr) begin
      case (cmd_e'(reg_wdata[1:0]))
        CMD_IDLE:  act_n = 1'b0;
        CMD_BLAST: st_n[ST_BLAST] = 1'b1;
        CMD_ABORT: if (active) begin
          st_n[ST_ABORT] = 1'b1;
          act_n = 1'b0;
        end
        CMD_START: if (!active && xfer_idle) begin
          act_n = 1'b1;
          wc_n  = start_cnt;
          wa_n  = spa;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CMD:    rd_mux[7:0]        = cmd_q;
      A_SCNT:   rd_mux[CNT_W-1:0]  = start_cnt;
      A_SADDR:  rd_mux[ADDR_W-1:0] = spa;
      A_DPTR:   rd_mux[ADDR_W-1:0] = desc_ptr;
      A_WCNT:   rd_mux[CNT_W-1:0]  = wcount;
      A_WADDR:  rd_mux[ADDR_W-1:0] = waddr;
      A_STATUS: rd_mux[ST_W-1:0]   = status;
      default:  rd_mux             = busctl;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      start_cnt <= '0;
      spa       <= '0;
      desc_ptr  <= '0;
      busctl    <= BC_RESET;
      status    <= '0;
      active    <= 1'b0;
      wcount    <= '0;
      waddr     <= '0;
      core_q    <= 1'b0;
      reg_rdata <= '0;
    end else begin
      core_q <= core_irq;
      status <= st_n;
      active <= act_n;
      wcount <= wc_n;
      waddr  <= wa_n;
      if (reg_rd) reg_rdata <= rd_mux;
      if (reg_wr) begin
        case (reg_addr)
          A_CMD:    cmd_q     <= reg_wdata[7:0];
          A_SCNT:   start_cnt <= reg_wdata[CNT_W-1:0];
          A_SADDR:  spa       <= reg_wdata[ADDR_W-1:0];
          A_DPTR:   desc_ptr  <= reg_wdata[ADDR_W-1:0];
          A_BUSCTL: busctl    <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  p_busctl_rst_r1: assert property (@(posedge clk) rst |=> (busctl == BC_RESET));

  p_start_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && (reg_wdata[1:0] == 2'd3) && active && !ev_data && !ev_ptr)
      |=> (wcount == $past(wcount)) && (waddr == $past(waddr)));

  p_done_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (ev_data && !ev_err && (ev_len == wcount)) |=> (status[ST_DONE] && !active));

  p_hold_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    (busctl[BC_HOLD_BIT] && status[ST_DONE] && !reg_wr) |=> status[ST_DONE]);
endmodule

// File: rtl/bmdma_xfer.sv
module bmdma_xfer
  import bmdma_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              desc_mode,
  input  logic [CNT_W-1:0]  wcount,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [ADDR_W-1:0] desc_ptr,
  input  logic [ADDR_W-1:0] spa,
  input  logic              chunk_req,
  input  logic [CNT_W-1:0]  chunk_len,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              chunk_ready,
  output logic              chunk_done,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CNT_W-1:0]  mem_len,
  output logic              mem_is_ptr,
  output logic              xfer_idle,
  output logic              ev_zero,
  output logic              ev_ptr,
  output logic [ADDR_W-1:0] ev_ptr_addr,
  output logic              ev_data,
  output logic [CNT_W-1:0]  ev_len,
  output logic              ev_err
);
  localparam logic [CNT_W-1:0] PTR_BYTES = CNT_W'(4);

  xstate_e          state;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] trim;
  logic             take;

  assign trim        = (chunk_len < wcount) ? chunk_len : wcount;
  assign xfer_idle   = (state == XS_IDLE);
  assign chunk_ready = active && xfer_idle;
  assign take        = chunk_ready && chunk_req;
  assign ev_zero     = take && (trim == '0);
  assign ev_ptr      = (state == XS_FETCH) && mem_ack && !mem_err;
  assign ev_ptr_addr = mem_rdata | spa;
  assign ev_data     = (state == XS_DATA) && mem_ack;
  assign ev_len      = mem_len;
  assign ev_err      = !xfer_idle && mem_ack && mem_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= XS_IDLE;
      len_q      <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      mem_len    <= '0;
      mem_is_ptr <= 1'b0;
      chunk_done <= 1'b0;
    end else begin
      chunk_done <= ev_data && !mem_err;
      case (state)
        XS_IDLE: if (take && (trim != '0)) begin
          len_q   <= trim;
          mem_req <= 1'b1;
          if (desc_mode) begin
            state      <= XS_FETCH;
            mem_addr   <= desc_ptr;
            mem_len    <= PTR_BYTES;
            mem_is_ptr <= 1'b1;
          end else begin
            state      <= XS_DATA;
            mem_addr   <= waddr;
            mem_len    <= trim;
            mem_is_ptr <= 1'b0;
          end
        end
        XS_FETCH: if (mem_ack) begin
          if (mem_err) begin
            state      <= XS_IDLE;
            mem_req    <= 1'b0;
            mem_is_ptr <= 1'b0;
          end else begin
            state      <= XS_DATA;
            mem_addr   <= ev_ptr_addr;
            mem_len    <= len_q;
            mem_is_ptr <= 1'b0;
          end
        end
        XS_DATA: if (mem_ack) begin
          state   <= XS_IDLE;
          mem_req <= 1'b0;
        end
        default: state <= XS_IDLE;
      endcase
    end
  end

  p_trim_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_is_ptr) |-> (mem_len <= wcount));

  p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_len)));

  p_ptr_len_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_is_ptr) |-> (mem_len == PTR_BYTES));
endmodule

// File: rtl/bmdma_irq.sv
module bmdma_irq (
  input  logic clk,
  input  logic rst,
  input  logic core_irq,
  input  logic dma_lvl,
  output logic inta
);
  always_ff @(posedge clk) begin
    if (rst) inta <= 1'b0;
    else     inta <= core_irq | dma_lvl;
  end

  p_inta_high_r11: assert property (@(posedge clk) disable iff (rst)
    (dma_lvl || core_irq) |=> inta);

  p_inta_low_r11: assert property (@(posedge clk) disable iff (rst)
    (!dma_lvl && !core_irq) |=> !inta);
endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine
  import bmdma_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              core_irq,
  input  logic              chunk_req,
  input  logic [CNT_W-1:0]  chunk_len,
  output logic              chunk_ready,
  output logic              chunk_done,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CNT_W-1:0]  mem_len,
  output logic              mem_is_ptr,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              inta
);
  logic              active, desc_mode, xfer_idle;
  logic [CNT_W-1:0]  wcount, ev_len;
  logic [ADDR_W-1:0] waddr, desc_ptr, spa, ev_ptr_addr;
  logic [ST_W-1:0]   status;
  logic              ev_zero, ev_ptr, ev_data, ev_err, dma_lvl;

  assign dma_lvl = status[ST_DONE] | status[ST_ERROR] | status[ST_ABORT];

  bmdma_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_irq(core_irq),
    .xfer_idle(xfer_idle), .ev_zero(ev_zero), .ev_ptr(ev_ptr),
    .ev_ptr_addr(ev_ptr_addr), .ev_data(ev_data), .ev_len(ev_len), .ev_err(ev_err),
    .active(active), .desc_mode(desc_mode), .wcount(wcount), .waddr(waddr),
    .desc_ptr(desc_ptr), .spa(spa), .status(status)
  );

  bmdma_xfer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_xfer (
    .clk(clk), .rst(rst), .active(active), .desc_mode(desc_mode), .wcount(wcount),
    .waddr(waddr), .desc_ptr(desc_ptr), .spa(spa), .chunk_req(chunk_req),
    .chunk_len(chunk_len), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .chunk_ready(chunk_ready), .chunk_done(chunk_done), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_len(mem_len), .mem_is_ptr(mem_is_ptr),
    .xfer_idle(xfer_idle), .ev_zero(ev_zero), .ev_ptr(ev_ptr),
    .ev_ptr_addr(ev_ptr_addr), .ev_data(ev_data), .ev_len(ev_len), .ev_err(ev_err)
  );

  bmdma_irq u_irq (
    .clk(clk), .rst(rst), .core_irq(core_irq), .dma_lvl(dma_lvl), .inta(inta)
  );
endmodule

// File: tb/sim_bmdma_engine.sv
module sim_bmdma_engine;
  localparam int CW = 12;
  localparam int AW = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic core_irq = 0, chunk_req = 0;
  logic [CW-1:0] chunk_len = 0;
  logic chunk_ready, chunk_done, mem_req, mem_is_ptr, inta;
  logic [AW-1:0] mem_addr;
  logic [CW-1:0] mem_len;
  logic mem_ack = 0, mem_err = 0;
  logic [AW-1:0] mem_rdata = 0;

  int vectors = 0, fails = 0, cyc = 0;
  bit finished = 0;

  logic [CW-1:0] m_wc;
  logic [AW-1:0] m_wa, m_spa, m_dptr;
  bit m_act = 0, m_desc = 0, m_hold = 0;
  bit m_blast = 0, m_abt = 0, m_err = 0, m_done = 0;

  always #2 clk = ~clk;

  bmdma_engine #(.CNT_W(CW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_irq(core_irq),
    .chunk_req(chunk_req), .chunk_len(chunk_len), .chunk_ready(chunk_ready),
    .chunk_done(chunk_done), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_len(mem_len), .mem_is_ptr(mem_is_ptr), .mem_ack(mem_ack),
    .mem_err(mem_err), .mem_rdata(mem_rdata), .inta(inta)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] exp_st();
    return {28'd0, m_done, m_err, m_abt, m_blast};
  endfunction

  function automatic logic [CW-1:0] exp_trim(input logic [CW-1:0] l, input logic [CW-1:0] c);
    return (l < c) ? l : c;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic rd_status(input string rq);
    logic [31:0] d;
    rd(3'd6, d);
    chk(d == exp_st(), rq, d, exp_st());
    if (!m_hold) begin m_done = 0; m_err = 0; m_abt = 0; end
  endtask

  task automatic chk_inta(input string rq);
    logic e;
    @(negedge clk);
    e = core_irq | m_done | m_err | m_abt;
    chk(inta == e, rq, 32'(inta), 32'(e));
  endtask

  task automatic chk_work(input string rq);
    logic [31:0] d;
    rd(3'd4, d); chk(d == 32'(m_wc), rq, d, 32'(m_wc));
    rd(3'd5, d); chk(d == m_wa, rq, d, m_wa);
  endtask

  task automatic start(input logic [CW-1:0] cnt, input logic [AW-1:0] sa,
                       input logic [AW-1:0] dp, input bit desc);
    wr(3'd1, 32'(cnt)); wr(3'd2, sa); wr(3'd3, dp);
    m_spa = sa; m_dptr = dp;
    wr(3'd0, desc ? 32'h83 : 32'h03);
    m_desc = desc;
    if (!m_act) begin m_act = 1; m_wc = cnt; m_wa = sa; end
  endtask

  task automatic serve(input logic [AW-1:0] ea, input logic [CW-1:0] el, input bit ep,
                       input logic [AW-1:0] rv, input bit err, input string rq);
    int w = 0;
    while (!mem_req && w < 20) begin @(negedge clk); w++; end
    chk(mem_req, rq, 32'(mem_req), 1);
    chk(mem_addr == ea, rq, mem_addr, ea);
    chk(mem_len == el, rq, 32'(mem_len), 32'(el));
    chk(mem_is_ptr == ep, rq, 32'(mem_is_ptr), 32'(ep));
    repeat ($urandom_range(0, 3)) @(negedge clk);
    mem_ack = 1; mem_err = err; mem_rdata = rv;
    @(negedge clk); mem_ack = 0; mem_err = 0;
  endtask

  task automatic chunk(input logic [CW-1:0] len);
    logic [CW-1:0] t;
    logic [AW-1:0] pv;
    t = exp_trim(len, m_wc);
    chunk_len = len; chunk_req = 1;
    @(negedge clk); chunk_req = 0;
    if (t == 0) begin
      @(negedge clk);
      chk(!mem_req, "R5 zero chunk", 32'(mem_req), 0);
      m_done = 1; m_act = 0;
    end else begin
      if (m_desc) begin
        pv = $urandom();
        serve(m_dptr, 4, 1, pv, 0, "R7 pointer fetch");
        m_wa = pv | m_spa;
        serve(m_wa, t, 0, 0, 0, "R7 descriptor data");
      end else begin
        serve(m_wa, t, 0, 0, 0, "R6 plain data");
      end
      m_wc = m_wc - t;
      if (!m_desc) m_wa = m_wa + AW'(t);
      if (m_wc == 0) begin m_done = 1; m_act = 0; end
    end
  endtask

  initial begin
    wait (cyc == 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [CW-1:0] c;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!inta && !mem_req && !chunk_ready, "R1 outputs", {inta, mem_req, chunk_ready}, 0);
    rd(3'd7, d); chk(d == 32'h0008_0000, "R1 busctl", d, 32'h0008_0000);
    rd_status("R1 status");

    // R3 blast sets bit 0, survives status reads
    wr(3'd0, 32'h1); m_blast = 1;
    rd_status("R3 blast set");
    rd_status("R3 blast kept");

    // R4 start ignored while active, then finish normally
    start(12'd50, 32'h1000, 32'h0, 0);
    start(12'd99, 32'h2000, 32'h0, 0);
    chk_work("R4 second start ignored");
    chunk(12'd30); chunk(12'd60);
    rd_status("R8 done plain");
    chk_inta("R11 inta low after clear");

    // R2 idle stops transfer
    start(12'd40, 32'h3000, 32'h0, 0);
    wr(3'd0, 32'h0); m_act = 0;
    chk(!chunk_ready, "R2 chunk_ready low", 32'(chunk_ready), 0);
    chunk_len = 8; chunk_req = 1; @(negedge clk); chunk_req = 0;
    repeat (3) @(negedge clk);
    chk(!mem_req, "R2 no request", 32'(mem_req), 0);
    chk_work("R2 count unchanged");

    // R5 R8 zero start count
    start(12'd0, 32'h4000, 32'h0, 0);
    chunk(12'd16);
    chk_inta("R11 inta from done");
    rd_status("R8 zero chunk done");

    // R9 core irq with nonzero count: no done; then with zero count: done
    start(12'd10, 32'h5000, 32'h0, 0);
    @(negedge clk); core_irq = 1;
    chk_inta("R11 inta from core");
    rd_status("R9 no done with count");
    core_irq = 0;
    wr(3'd0, 32'h0); m_act = 0;
    start(12'd0, 32'h5000, 32'h0, 0);
    @(negedge clk); core_irq = 1; @(negedge clk); core_irq = 0;
    m_done = 1; m_act = 0;
    chk_inta("R9 inta after core done");
    rd_status("R9 done by core irq");

    // R10 hold bit keeps status
    wr(3'd7, 32'h0008_0001); m_hold = 1;
    start(12'd20, 32'h6000, 32'h0, 0);
    chunk(12'd20);
    rd_status("R10 held first read");
    rd_status("R10 held second read");
    chk_inta("R10 inta still high");
    wr(3'd7, 32'h0008_0000); m_hold = 0;
    rd_status("R10 cleared after hold off");

    // R12 memory error
    start(12'd20, 32'h7000, 32'h0, 0);
    chunk_len = 10; chunk_req = 1; @(negedge clk); chunk_req = 0;
    serve(32'h7000, 10, 0, 0, 1, "R12 request");
    m_err = 1; m_act = 0;
    chk(!chunk_ready, "R12 ended", 32'(chunk_ready), 0);
    chk_work("R12 count unchanged");
    rd_status("R12 error bit");

    // R13 abort
    start(12'd30, 32'h8000, 32'h0, 0);
    wr(3'd0, 32'h2); m_abt = 1; m_act = 0;
    chk(!chunk_ready, "R13 ended", 32'(chunk_ready), 0);
    chk_inta("R13 inta");
    rd_status("R13 abort bit");

    // random transfers in both modes
    for (int n = 0; n < 40; n++) begin
      c = CW'($urandom_range(1, 300));
      start(c, $urandom(), $urandom(), bit'($urandom_range(0, 1)));
      while (m_wc != 0) begin
        chunk(CW'($urandom_range(1, 80)));
        chk_work(m_desc ? "R7 work regs" : "R6 work regs");
      end
      chk_inta("R11 inta random done");
      rd_status("R8 random done");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule